// File: doc/BRIEF.md
# Staged Leading-Zero Counter (24-bit)

This block reports how many zero bits sit above the most significant one in a 24-bit word, the shift amount a floating-point normalizer needs. Rather than walking the word bit by bit, it passes the word through a fixed chain of five tests. Each test looks at the top bits of a working copy of the word. If those bits are all zero, the test adds their number to a running count and shifts the copy left by the same amount, so that the next test again looks at the top.

The tests use widths of 12, 6, 3, 2 and 1 bits, in that order. They add up to 24, so a word with no ones at all gives a count of 24. The chain is purely combinational. A single output register captures the count on a rising clock edge when the input strobe is high, and keeps its value while the strobe is low. The output valid flag repeats the strobe one cycle later.

Top module: `lzc24_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `out_valid` becomes 0 and `out_count` becomes 0 at that edge (synchronous, active-low reset).
- R2: `out_valid` after a rising edge equals the value `in_valid` had at that edge: one cycle of latency, with no other condition.
- R3: When `in_valid` is high at an edge and `in_data` is not zero, `out_count` after that edge equals 23 minus the index of the highest set bit of `in_data` (bit 23 is the most significant bit).
- R4: When `in_valid` is high at an edge and `in_data` is all zero, `out_count` after that edge is 24.
- R5: When `in_valid` is high at an edge and bit 23 of `in_data` is set, `out_count` after that edge is 0, whatever the lower bits hold.
- R6: When `in_valid` is high at an edge and bit 0 is the only set bit of `in_data`, `out_count` after that edge is 23.
- R7: When `in_valid` is low at an edge, `out_count` keeps its value across that edge, whatever `in_data` holds.
- R8: `out_count` never exceeds 24.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | High when `in_data` holds a word to be counted |
| in_data | input | 24 | Word whose leading zeros are counted; bit 23 is the most significant bit |
| out_count | output | 5 | Registered count of leading zeros, from 0 to 24 |
| out_valid | output | 1 | High in the cycle after a word was accepted |

## Verification
Several properties are checked on every clock cycle:
- the one-cycle latency of the valid flag;
- the count holding its value while the strobe is low;
- the upper bound of 24 on the count;
- the three fixed-result cases: a zero word, bit 23 set, and a word whose only one is bit 0.

The general mapping from each word to its exact count is shown only by the bench's scenarios. Those scenarios compare every result with a loop-based reference and use:
- all 24 one-hot words;
- random words whose leading-zero depth is spread over the whole range;
- directed words that hold the same value across several cycles with the strobe low.

// File: rtl/lzc_pkg.sv
// Package: shared sizes for the staged leading-zero counter.
// Assumes the stage widths sum to the data width, so an all-zero word
// reaches the full count.
package lzc_pkg;
    localparam int LZC_DATA_W  = 24;
    localparam int LZC_CNT_W   = $clog2(LZC_DATA_W + 1);
    localparam int LZC_STAGES  = 5;
    localparam int LZC_STAGE_W [LZC_STAGES] = '{12, 6, 3, 2, 1};
endpackage

// File: rtl/lzc_stage.sv
// Module: one test of the leading-zero chain.
// It checks the top TEST_W bits of the working word. If they are all zero,
// it adds TEST_W to the count and shifts the word left by TEST_W.
// Assumes the incoming count plus TEST_W fits in CNT_W bits.
module lzc_stage #(
    parameter int DATA_W = 24,
    parameter int CNT_W  = 5,
    parameter int TEST_W = 12
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [DATA_W-1:0] word_o,
    output logic [CNT_W-1:0]  cnt_o
);
    logic top_zero;

    // Purpose: detect an all-zero top slice of the working word.
    assign top_zero = (word_i[DATA_W-1 -: TEST_W] == '0);

    // Purpose: move the lower part into view and extend the count.
    always_comb begin
        word_o = word_i;
        cnt_o  = cnt_i;
        if (top_zero) begin
            word_o = word_i << TEST_W;
            cnt_o  = cnt_i + CNT_W'(TEST_W);
        end
    end
endmodule

// File: rtl/lzc24_top.sv
// Module: staged leading-zero counter with one output register.
// It chains one lzc_stage per entry of LZC_STAGE_W and registers the final
// count when in_valid is high. Uses a synchronous active-low reset.
// Assumes the entries of LZC_STAGE_W sum to DATA_W.
module lzc24_top
    import lzc_pkg::*;
#(
    parameter int DATA_W = LZC_DATA_W,
    parameter int CNT_W  = LZC_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic [CNT_W-1:0]  out_count,
    output logic              out_valid
);
    localparam int NST = LZC_STAGES;

    logic [(NST+1)*DATA_W-1:0] word_chain;
    logic [(NST+1)*CNT_W-1:0]  cnt_chain;
    logic [CNT_W-1:0]          cnt_final;

    assign word_chain[DATA_W-1:0] = in_data;
    assign cnt_chain[CNT_W-1:0]   = '0;

    genvar gi;
    generate
        for (gi = 0; gi < NST; gi++) begin : g_stage
            lzc_stage #(
                .DATA_W (DATA_W),
                .CNT_W  (CNT_W),
                .TEST_W (LZC_STAGE_W[gi])
            ) u_stage (
                .word_i (word_chain[gi*DATA_W +: DATA_W]),
                .cnt_i  (cnt_chain[gi*CNT_W +: CNT_W]),
                .word_o (word_chain[(gi+1)*DATA_W +: DATA_W]),
                .cnt_o  (cnt_chain[(gi+1)*CNT_W +: CNT_W])
            );
        end
    endgenerate

    assign cnt_final = cnt_chain[NST*CNT_W +: CNT_W];

    // Purpose: capture the count on an accepted word and track the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_count <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_count <= cnt_final;
        end
    end

    // Checks on the output register and the fixed-result cases.
    assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_zero_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_data == '0) |=> (out_count == CNT_W'(DATA_W)));
    assert_top_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_data[DATA_W-1]) |=> (out_count == '0));
    assert_low_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_data == DATA_W'(1)) |=> (out_count == CNT_W'(DATA_W-1)));
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_count));
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_count <= CNT_W'(DATA_W));
endmodule

// File: tb/tb_lzc24_top.sv
`timescale 1ns/1ps
module tb_lzc24_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] in_data = '0;
    logic [4:0]  out_count;
    logic        out_valid;
    int          n_checks = 0;
    int          n_fail = 0;

    lzc24_top dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_count(out_count), .out_valid(out_valid)
    );

    always #2.5 clk = ~clk;

    // Reference: scan from the top bit down and count zeros until a one is found.
    function automatic int ref_lz(input logic [23:0] w);
        int n = 0;
        for (int i = 23; i >= 0; i--) begin
            if (w[i]) return n;
            n++;
        end
        return n;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one word at a falling edge, then sample at the next falling edge.
    task automatic apply(input logic [23:0] w, input string req);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        @(negedge clk);
        check(req, int'(out_count), ref_lz(w));
        check("R2", int'(out_valid), 1);
        in_valid = 1'b0;
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [23:0] w;
        logic [4:0]  held;
        void'($urandom(32'd20240225));
        in_data = 24'hABCDEF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", int'(out_valid), 0);
        check("R1", int'(out_count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2", int'(out_valid), 0);

        apply(24'h000000, "R4");
        apply(24'hFFFFFF, "R5");
        apply(24'h800001, "R5");
        apply(24'h000001, "R6");
        apply(24'h000FFF, "R3");
        apply(24'h0001A5, "R3");
        for (int i = 0; i < 24; i++) apply(24'h1 << i, "R3");

        // Strobe low: the count must hold and the valid flag must drop.
        apply(24'h00F000, "R3");
        held = out_count;
        for (int k = 0; k < 4; k++) begin
            in_data = (k % 2 == 0) ? 24'h000000 : 24'h800000;
            @(negedge clk);
            check("R7", int'(out_count), int'(held));
            check("R2", int'(out_valid), 0);
        end

        // Random words with leading zeros spread over the whole range.
        for (int j = 0; j < 400; j++) begin
            w = 24'($urandom()) >> ($urandom() % 25);
            apply(w, "R3");
            check("R8", int'(out_count <= 5'd24), 1);
        end

        // Reset again in the middle of a run.
        apply(24'h000010, "R3");
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", int'(out_count), 0);
        check("R1", int'(out_valid), 0);
        finish_run();
    end
endmodule